// File: doc/BRIEF.md
# Two-wire bus condition control register

This block is the control and status register of a two-wire serial bus port. Software uses it to form bus conditions by moving the data-output latch. A stop trigger raises the latch and a start trigger drops it. Software can also hold the data line low for an acknowledge until the clock line next falls. The register also records start and stop conditions that a separate bus monitor reports, so software can poll them.

Software reaches the register through an 8-bit port. That port takes full-byte writes and single-bit writes (a bit index plus a value), and a combinational read returns the current contents. The command bits clear themselves once their action is done. Each status flag follows its own set of set and clear events. Dropping the port enable wipes every command and flag.

Top module: `sbus_cond_reg`

## Requirements
- R1: While reset is asserted, `rd_data` reads 00h, `so_latch` is 1 and `sda_force_low` is 0.
- R2: Writing 1 to bit 0 (stop trigger) while the port is enabled makes bit 0 read 1 for exactly one cycle. `so_latch` becomes 1 at the following clock edge, and at that same edge bit 0 returns to 0.
- R3: Writing 1 to bit 1 (start trigger) while the port is enabled makes bit 1 read 1 for one cycle, and then `so_latch` becomes 0. When both triggers are pending together, the stop action wins and the latch goes to 1.
- R4: Bit 2 (stop seen) sets on a `stop_det` strobe. It clears on `xfer_start`, on `addr_miss` or while `port_en` is 0. A clear event in the same cycle as a set wins.
- R5: Bit 3 (start seen) sets on a `start_det` strobe. It clears on `xfer_start`, on `stop_det` or while `port_en` is 0. A clear wins, so a start and a stop in the same cycle leave it at 0.
- R6: Writing 1 to bit 4 (ack trigger) drives `sda_force_low` and makes bit 4 read 1 from the next cycle on. Both drop at the clock edge where `scl_in` is sampled low after having been sampled high. They also drop on `xfer_start`. A falling edge in the same cycle as the write wins over the write.
- R7: While `port_en` is 0, bits 0 to 4 are cleared at each edge and trigger writes take no effect. `so_latch` keeps its value.
- R8: Bit 5 (ack enable) and bit 7 (busy enable) store whatever value is written, by either write form.
- R9: Bits 2, 3 and 6 are read-only. Bit 6 always reads 0, and writes of either form do not alter bits 2, 3 or 6.
- R10: A single-bit write updates only the bit selected by `bit_sel`. When `wr_en` and `bit_wr` are both high, only the byte write is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte write value |
| bit_wr | input | 1 | Single-bit write strobe |
| bit_sel | input | 3 | Bit index for the single-bit write |
| bit_val | input | 1 | Value for the single-bit write |
| rd_data | output | 8 | Current register contents |
| port_en | input | 1 | Port enable; 0 clears commands and flags |
| start_det | input | 1 | Start condition detected strobe |
| stop_det | input | 1 | Stop condition detected strobe |
| xfer_start | input | 1 | Transfer start strobe |
| addr_miss | input | 1 | Address mismatch strobe during address reception |
| scl_in | input | 1 | Clock line level |
| so_latch | output | 1 | Data-output latch value |
| sda_force_low | output | 1 | Hold data line low (acknowledge) |

## Verification
Every register bit reflects a write or a strobe one clock edge after the cycle that presented it. The data-output latch moves one edge later still, because the trigger must first be captured and is then acted on. The acknowledge hold drops at the edge where the registered previous clock level is high and the sampled level is low. The bench drives inputs on the falling clock edge and advances a behavioural model on each rising edge. It compares every output field with that model on the next falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/sbus_cond_reg.sv
module sbus_cond_reg #(
  parameter int W = 8,
  localparam int SW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          bit_wr,
  input  logic [SW-1:0] bit_sel,
  input  logic          bit_val,
  output logic [W-1:0]  rd_data,
  input  logic          port_en,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          xfer_start,
  input  logic          addr_miss,
  input  logic          scl_in,
  output logic          so_latch,
  output logic          sda_force_low
);
  localparam int B_STOPT = 0;
  localparam int B_STRTT = 1;
  localparam int B_STOPF = 2;
  localparam int B_STRTF = 3;
  localparam int B_ACKT  = 4;
  localparam int B_ACKEN = 5;
  localparam int B_ACKF  = 6;
  localparam int B_BUSY  = 7;

  logic stop_t, start_t, ack_t, stop_f, start_f, ack_en, busy_en, scl_q;
  logic [W-1:0] wmask, wval, wset;
  logic scl_fall;

  always_comb begin
    wmask = '0;
    wval  = '0;
    if (wr_en) begin
      wmask = '1;
      wval  = wr_data;
    end else if (bit_wr) begin
      wmask[bit_sel] = 1'b1;
      wval = {W{bit_val}};
    end
  end

  assign wset     = wmask & wval;
  assign scl_fall = scl_q & ~scl_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_t   <= 1'b0;
      start_t  <= 1'b0;
      ack_t    <= 1'b0;
      stop_f   <= 1'b0;
      start_f  <= 1'b0;
      ack_en   <= 1'b0;
      busy_en  <= 1'b0;
      scl_q    <= 1'b1;
      so_latch <= 1'b1;
    end else begin
      scl_q <= scl_in;
      if (port_en && stop_t)       so_latch <= 1'b1;
      else if (port_en && start_t) so_latch <= 1'b0;
      stop_t  <= port_en & wset[B_STOPT];
      start_t <= port_en & wset[B_STRTT];
      ack_t   <= port_en & ~xfer_start & ~scl_fall & (wset[B_ACKT] | ack_t);
      stop_f  <= port_en & ~xfer_start & ~addr_miss & (stop_det | stop_f);
      start_f <= port_en & ~xfer_start & ~stop_det & (start_det | start_f);
      if (wmask[B_ACKEN]) ack_en  <= wval[B_ACKEN];
      if (wmask[B_BUSY])  busy_en <= wval[B_BUSY];
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[B_STOPT] = stop_t;
    rd_data[B_STRTT] = start_t;
    rd_data[B_STOPF] = stop_f;
    rd_data[B_STRTF] = start_f;
    rd_data[B_ACKT]  = ack_t;
    rd_data[B_ACKEN] = ack_en;
    rd_data[B_ACKF]  = 1'b0;
    rd_data[B_BUSY]  = busy_en;
  end

  assign sda_force_low = ack_t;

  assert_stop_sets_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && stop_t) |=> so_latch);
  assert_start_clears_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && start_t && !stop_t) |=> !so_latch);
  assert_stop_flag_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (port_en && stop_det && !xfer_start && !addr_miss) |=> rd_data[B_STOPF]);
  assert_stop_clears_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !rd_data[B_STRTF]);
  assert_ack_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_q && !scl_in) |=> !sda_force_low);
  assert_disable_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> (rd_data[B_ACKT:B_STOPT] == '0) && $stable(so_latch));
endmodule

// File: tb/sim_sbus_cond_reg.sv
module sim_sbus_cond_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 0, bit_wr = 0, bit_val = 0;
  logic [7:0] wr_data = 0;
  logic [2:0] bit_sel = 0;
  logic port_en = 0, start_det = 0, stop_det = 0, xfer_start = 0, addr_miss = 0;
  logic scl_in = 1;
  logic [7:0] rd_data;
  logic so_latch, sda_force_low;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sbus_cond_reg u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .bit_wr(bit_wr), .bit_sel(bit_sel), .bit_val(bit_val), .rd_data(rd_data),
    .port_en(port_en), .start_det(start_det), .stop_det(stop_det),
    .xfer_start(xfer_start), .addr_miss(addr_miss), .scl_in(scl_in),
    .so_latch(so_latch), .sda_force_low(sda_force_low)
  );

  int m_reg[8];
  int m_latch, m_scl;
  int last_dis, last_bitwr;

  function automatic int wr_hit(int i, output int v);
    if (wr_en) begin v = wr_data[i]; return 1; end
    if (bit_wr && int'(bit_sel) == i) begin v = bit_val; return 1; end
    v = 0;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_reg[i]) m_reg[i] = 0;
      m_latch = 1; m_scl = 1; last_dis = 0; last_bitwr = 0;
    end else begin
      int v, h, fall;
      int n[8];
      fall = (m_scl == 1 && scl_in == 0);
      n = m_reg;
      if (port_en && m_reg[0]) m_latch = 1;
      else if (port_en && m_reg[1]) m_latch = 0;
      h = wr_hit(0, v); n[0] = (port_en && h && v) ? 1 : 0;
      h = wr_hit(1, v); n[1] = (port_en && h && v) ? 1 : 0;
      h = wr_hit(4, v);
      n[4] = (port_en && !xfer_start && !fall && ((h && v) || m_reg[4])) ? 1 : 0;
      n[2] = (port_en && !xfer_start && !addr_miss && (stop_det || m_reg[2])) ? 1 : 0;
      n[3] = (port_en && !xfer_start && !stop_det && (start_det || m_reg[3])) ? 1 : 0;
      h = wr_hit(5, v); if (h) n[5] = v;
      h = wr_hit(7, v); if (h) n[7] = v;
      n[6] = 0;
      m_reg = n;
      m_scl = scl_in;
      last_dis = !port_en;
      last_bitwr = bit_wr && !wr_en;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int mbyte();
    int b = 0;
    for (int i = 0; i < 8; i++) b |= (m_reg[i] & 1) << i;
    return b;
  endfunction

  task automatic compare();
    chk("R2 stop trigger bit", rd_data[0], m_reg[0]);
    chk("R3 start trigger bit", rd_data[1], m_reg[1]);
    chk("R4 stop seen flag", rd_data[2], m_reg[2]);
    chk("R5 start seen flag", rd_data[3], m_reg[3]);
    chk("R6 ack trigger bit", rd_data[4], m_reg[4]);
    chk("R6 data low override", sda_force_low, m_reg[4]);
    chk("R8 ack enable bit", rd_data[5], m_reg[5]);
    chk("R8 busy enable bit", rd_data[7], m_reg[7]);
    chk("R9 read-only bit 6", rd_data[6], 0);
    chk("R2/R3 output latch", so_latch, m_latch);
    if (last_dis) chk("R7 disabled clears commands and flags", rd_data[4:0], 0);
    if (last_bitwr) chk("R10 single-bit write byte", rd_data, mbyte());
  endtask

  task automatic idle();
    wr_en = 0; bit_wr = 0; start_det = 0; stop_det = 0; xfer_start = 0; addr_miss = 0;
  endtask

  task automatic step();
    @(negedge clk);
    compare();
    idle();
  endtask

  task automatic wbyte(int d);
    step(); wr_en = 1; wr_data = d[7:0];
  endtask

  task automatic wbit(int s, int v);
    step(); bit_wr = 1; bit_sel = s[2:0]; bit_val = v[0];
  endtask

  initial begin
    #1;
    @(negedge clk);
    chk("R1 reset register", rd_data, 0);
    chk("R1 reset latch", so_latch, 1);
    chk("R1 reset override", sda_force_low, 0);
    rst_n = 1;
    port_en = 1;
    wbyte('h02); step(); step();
    wbyte('h01); step(); step();
    wbyte('h03); step(); step();
    wbyte('h10); step(); scl_in = 1; step(); scl_in = 0; step(); step();
    step(); start_det = 1; step(); stop_det = 1; step();
    step(); start_det = 1; stop_det = 1; step();
    step(); stop_det = 1; addr_miss = 1; step();
    wbyte('hFF); step();
    wbit(7, 0); wbit(6, 1); wbit(5, 0); wbit(3, 1);
    step(); wr_en = 1; wr_data = 'h80; bit_wr = 1; bit_sel = 5; bit_val = 1; step();
    step(); port_en = 0; wr_en = 1; wr_data = 'h13; step(); step();
    port_en = 1;
    scl_in = 1; wbyte('h10); scl_in = 0; step(); step();
    for (int k = 0; k < 4000; k++) begin
      step();
      port_en    = ($urandom_range(0, 9) != 0);
      scl_in     = $urandom_range(0, 1);
      start_det  = ($urandom_range(0, 7) == 0);
      stop_det   = ($urandom_range(0, 9) == 0);
      xfer_start = ($urandom_range(0, 15) == 0);
      addr_miss  = ($urandom_range(0, 15) == 0);
      wr_en      = ($urandom_range(0, 7) == 0);
      wr_data    = 8'($urandom);
      bit_wr     = ($urandom_range(0, 5) == 0);
      bit_sel    = 3'($urandom);
      bit_val    = $urandom_range(0, 1);
    end
    step();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule